// File: doc/BRIEF.md
# Segment Address Generator with Bounds Check

This block forms a 32-bit linear address from a segment-relative offset and a segment descriptor held in a register next to the address path. The descriptor fields come in as plain signals: base, a 20-bit limit, a granularity bit, a grow-downward bit, a big bit, a code/data bit and a writable bit. Each request also carries an offset, an access size code, a write flag and a flag that says whether the access goes through the stack segment.

The block is one registered stage. A request presented in one cycle produces, one clock edge later, either a linear address with a valid strobe or a fault with an 8-bit exception vector. It checks both the first and the last byte of the access against the scaled limit. Grow-downward data segments are valid above the limit instead of below it. Writes are checked against the segment type. A stack-segment limit violation gets its own vector, distinct from the general protection vector.

Top module: `seg_addr_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, both linValid and faultValid are 0.
- R2: A request that passes all checks sets linValid one cycle later, with linAddr equal to (base + offset) mod 2^32.
- R3: With gran=0, a normal segment accepts an access only if its last byte offset is at most the 20-bit limit.
- R4: With gran=1, the bound is the limit shifted left by 12 with the low 12 bits set to one.
- R5: The access length is 1, 2, 4 or 8 bytes for sizeCode 0, 1, 2, 3, and the last byte is offset + length - 1. An access whose last byte passes 0xFFFFFFFF is out of bounds for every segment kind.
- R6: For a data segment with expDown=1, the first byte must be strictly above the scaled limit and the last byte must not exceed 0xFFFFFFFF (big=1) or 0x0000FFFF (big=0).
- R7: A bounds violation raises vector 12 when isStack=1 and vector 13 otherwise.
- R8: A write (isWrite=1) to a code segment (isCode=1), or to a data segment with writable=0, raises vector 13 even when the access is also out of bounds and isStack=1.
- R9: One cycle after a request exactly one of linValid and faultValid is 1. One cycle after a cycle without a request both are 0.
- R10: With gran=1 and limit 0xFFFFF, every non-wrapping access to a normal segment is accepted.
- R11: On a code segment expDown has no effect, and the bound is checked as for a normal segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| offset | input | 32 | Segment-relative byte offset |
| sizeCode | input | 2 | Access length code (1, 2, 4, 8 bytes) |
| isWrite | input | 1 | Access is a write |
| isStack | input | 1 | Access goes through the stack segment |
| segBase | input | 32 | Descriptor base |
| segLimit | input | 20 | Descriptor raw limit |
| segGran | input | 1 | Limit counts 4 KB units |
| segExpDown | input | 1 | Data segment grows downward |
| segBig | input | 1 | Grow-downward upper bound is 4 GB rather than 64 KB |
| segCode | input | 1 | Segment is code |
| segWritable | input | 1 | Data segment accepts writes |
| linValid | output | 1 | Linear address issued |
| linAddr | output | 32 | Linear address, meaningful only with linValid |
| faultValid | output | 1 | Fault raised |
| faultVector | output | 8 | Exception vector, 12 or 13 |

## Verification
The hardest cases to reach are those where several rules meet on one access: a write to a read-only stack segment that is also out of bounds, and a multi-byte access whose first byte is legal while its last byte crosses the bound, the 64 KB top of a small grow-downward segment, or the end of the 32-bit space. Random offsets almost never land there. Directed requests therefore place the offset exactly at the scaled limit, one byte on either side of it, and within eight bytes of 0xFFFFFFFF. A random phase then draws limits from the values 0, all ones and small, and draws offsets near the scaled bound. A cycle-by-cycle behavioural model predicts every outcome.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  typedef struct packed {
    logic issue;
    logic raiseGp;
    logic raiseSs;
  } seg_strobe_t;

endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import seg_addr_pkg::*;
(
  input  logic        reqValid,
  input  logic        isWrite,
  input  logic        isStack,
  input  logic        segCode,
  input  logic        segWritable,
  input  logic        inBounds,
  output seg_strobe_t strobe
);

  logic typeBad;
  logic boundBad;

  always_comb begin
    typeBad  = isWrite && (segCode || !segWritable);
    boundBad = !inBounds;
    strobe.issue   = reqValid && !typeBad && !boundBad;
    strobe.raiseSs = reqValid && !typeBad && boundBad && isStack;
    strobe.raiseGp = reqValid && (typeBad || (boundBad && !isStack));
  end

endmodule

// File: rtl/seg_addr_dp.sv
module seg_addr_dp
  import seg_addr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LIMIT_W    = 20,
  parameter int GRAN_SHIFT = 12,
  parameter int SIZE_W     = 2,
  parameter int SMALL_W    = 16,
  parameter int VEC_W      = 8,
  parameter int SS_VEC     = 12,
  parameter int GP_VEC     = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] offset,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic [ADDR_W-1:0] segBase,
  input  logic [LIMIT_W-1:0] segLimit,
  input  logic              segGran,
  input  logic              segExpDown,
  input  logic              segBig,
  input  logic              segCode,
  input  seg_strobe_t       strobe,
  output logic              inBounds,
  output logic              linValid,
  output logic [ADDR_W-1:0] linAddr,
  output logic              faultValid,
  output logic [VEC_W-1:0]  faultVector
);

  localparam int SCALED_W = LIMIT_W + GRAN_SHIFT;
  localparam logic [ADDR_W-1:0] SMALL_TOP = {{(ADDR_W-SMALL_W){1'b0}}, {SMALL_W{1'b1}}};
  localparam logic [ADDR_W-1:0] BIG_TOP   = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] byteLimit;
  logic [ADDR_W-1:0] pageLimit;
  logic [ADDR_W-1:0] effLimit;
  logic [ADDR_W:0]   lastExt;
  logic [ADDR_W-1:0] lastByte;
  logic [ADDR_W-1:0] downTop;
  logic              wraps;
  logic              normalOk;
  logic              downOk;

  assign byteLimit = {{(ADDR_W-LIMIT_W){1'b0}}, segLimit};

  generate
    if (SCALED_W >= ADDR_W) begin : g_full
      logic [SCALED_W-1:0] scaled;
      assign scaled    = {segLimit, {GRAN_SHIFT{1'b1}}};
      assign pageLimit = scaled[ADDR_W-1:0];
    end else begin : g_narrow
      assign pageLimit = {{(ADDR_W-SCALED_W){1'b0}}, segLimit, {GRAN_SHIFT{1'b1}}};
    end
  endgenerate

  always_comb begin
    effLimit = segGran ? pageLimit : byteLimit;
    lastExt  = {1'b0, offset} + (({{ADDR_W{1'b0}}, 1'b1}) << sizeCode) - {{ADDR_W{1'b0}}, 1'b1};
    lastByte = lastExt[ADDR_W-1:0];
    wraps    = lastExt[ADDR_W];
    downTop  = segBig ? BIG_TOP : SMALL_TOP;
    normalOk = !wraps && (lastByte <= effLimit);
    downOk   = !wraps && (offset > effLimit) && (lastByte <= downTop);
    inBounds = (segExpDown && !segCode) ? downOk : normalOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linValid    <= 1'b0;
      faultValid  <= 1'b0;
      faultVector <= '0;
      linAddr     <= '0;
    end else begin
      linValid   <= strobe.issue;
      faultValid <= strobe.raiseGp || strobe.raiseSs;
      if (strobe.raiseSs)      faultVector <= VEC_W'(SS_VEC);
      else if (strobe.raiseGp) faultVector <= VEC_W'(GP_VEC);
      else                     faultVector <= '0;
      if (strobe.issue) linAddr <= segBase + offset;
    end
  end

endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
  import seg_addr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LIMIT_W    = 20,
  parameter int GRAN_SHIFT = 12,
  parameter int SIZE_W     = 2,
  parameter int SMALL_W    = 16,
  parameter int VEC_W      = 8,
  parameter int SS_VEC     = 12,
  parameter int GP_VEC     = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  offset,
  input  logic [SIZE_W-1:0]  sizeCode,
  input  logic               isWrite,
  input  logic               isStack,
  input  logic [ADDR_W-1:0]  segBase,
  input  logic [LIMIT_W-1:0] segLimit,
  input  logic               segGran,
  input  logic               segExpDown,
  input  logic               segBig,
  input  logic               segCode,
  input  logic               segWritable,
  output logic               linValid,
  output logic [ADDR_W-1:0]  linAddr,
  output logic               faultValid,
  output logic [VEC_W-1:0]   faultVector
);

  seg_strobe_t strobe;
  logic        inBounds;

  seg_addr_ctrl u_ctrl (
    .reqValid   (reqValid),
    .isWrite    (isWrite),
    .isStack    (isStack),
    .segCode    (segCode),
    .segWritable(segWritable),
    .inBounds   (inBounds),
    .strobe     (strobe)
  );

  seg_addr_dp #(
    .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .GRAN_SHIFT(GRAN_SHIFT), .SIZE_W(SIZE_W),
    .SMALL_W(SMALL_W), .VEC_W(VEC_W), .SS_VEC(SS_VEC), .GP_VEC(GP_VEC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .offset     (offset),
    .sizeCode   (sizeCode),
    .segBase    (segBase),
    .segLimit   (segLimit),
    .segGran    (segGran),
    .segExpDown (segExpDown),
    .segBig     (segBig),
    .segCode    (segCode),
    .strobe     (strobe),
    .inBounds   (inBounds),
    .linValid   (linValid),
    .linAddr    (linAddr),
    .faultValid (faultValid),
    .faultVector(faultVector)
  );

endmodule

// File: rtl/seg_addr_checker.sv
module seg_addr_checker #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 2,
  parameter int VEC_W  = 8,
  parameter int SS_VEC = 12,
  parameter int GP_VEC = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] offset,
  input logic [SIZE_W-1:0] sizeCode,
  input logic              isWrite,
  input logic              isStack,
  input logic [ADDR_W-1:0] segBase,
  input logic              segCode,
  input logic              segWritable,
  input logic              linValid,
  input logic [ADDR_W-1:0] linAddr,
  input logic              faultValid,
  input logic [VEC_W-1:0]  faultVector
);

  logic [ADDR_W:0]   endX;
  logic              prevReq, prevWr, prevStack, prevCode, prevWritable, prevWrap;
  logic [ADDR_W-1:0] prevSum;

  assign endX = {1'b0, offset} + ((ADDR_W+1)'(1) << sizeCode) - (ADDR_W+1)'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevReq <= 1'b0; prevWr <= 1'b0; prevStack <= 1'b0; prevCode <= 1'b0;
      prevWritable <= 1'b0; prevWrap <= 1'b0; prevSum <= '0;
    end else begin
      prevReq      <= reqValid;
      prevWr       <= isWrite;
      prevStack    <= isStack;
      prevCode     <= segCode;
      prevWritable <= segWritable;
      prevWrap     <= endX[ADDR_W];
      prevSum      <= segBase + offset;
    end
  end

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !prevReq |-> (!linValid && !faultValid));

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rstN)
    prevReq |-> ($countones({linValid, faultValid}) == 1));

  assert_addr_sum_R2: assert property (@(posedge clk) disable iff (!rstN)
    linValid |-> (linAddr == prevSum));

  assert_vector_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> (faultVector == VEC_W'(GP_VEC) || faultVector == VEC_W'(SS_VEC)));

  assert_non_stack_gp_R7: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && !prevStack) |-> (faultVector == VEC_W'(GP_VEC)));

  assert_code_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (prevReq && prevWr && prevCode) |-> (faultValid && faultVector == VEC_W'(GP_VEC)));

  assert_readonly_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (prevReq && prevWr && !prevWritable) |-> (faultValid && faultVector == VEC_W'(GP_VEC)));

  assert_wrap_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    (prevReq && prevWrap) |-> faultValid);

endmodule

bind seg_addr_unit seg_addr_checker #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .VEC_W(VEC_W), .SS_VEC(SS_VEC), .GP_VEC(GP_VEC)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .offset(offset), .sizeCode(sizeCode),
  .isWrite(isWrite), .isStack(isStack), .segBase(segBase), .segCode(segCode),
  .segWritable(segWritable), .linValid(linValid), .linAddr(linAddr),
  .faultValid(faultValid), .faultVector(faultVector)
);

// File: tb/seg_addr_unit_test.sv
module seg_addr_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] offset = '0;
  logic [1:0]  sizeCode = '0;
  logic        isWrite = 1'b0, isStack = 1'b0;
  logic [31:0] segBase = '0;
  logic [19:0] segLimit = '0;
  logic        segGran = 1'b0, segExpDown = 1'b0, segBig = 1'b0, segCode = 1'b0, segWritable = 1'b1;
  logic        linValid, faultValid;
  logic [31:0] linAddr;
  logic [7:0]  faultVector;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  seg_addr_unit uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .offset(offset), .sizeCode(sizeCode),
    .isWrite(isWrite), .isStack(isStack), .segBase(segBase), .segLimit(segLimit),
    .segGran(segGran), .segExpDown(segExpDown), .segBig(segBig), .segCode(segCode),
    .segWritable(segWritable), .linValid(linValid), .linAddr(linAddr),
    .faultValid(faultValid), .faultVector(faultVector)
  );

  function automatic void predict(output bit eV, output bit eF, output int eVec,
                                  output longint unsigned eA);
    longint unsigned len, last, lim, top, off;
    bit ok;
    eV = 0; eF = 0; eVec = 0; eA = 0;
    if (!reqValid) return;
    off  = longint'(offset);
    len  = 64'd1 << sizeCode;
    last = off + len - 1;
    lim  = segGran ? (longint'(segLimit) * 4096 + 4095) : longint'(segLimit);
    if (isWrite && (segCode || !segWritable)) begin
      eF = 1; eVec = 13; return;
    end
    if (segCode || !segExpDown) ok = (last <= 64'hFFFF_FFFF) && (last <= lim);
    else begin
      top = segBig ? 64'hFFFF_FFFF : 64'h0000_FFFF;
      ok  = (off > lim) && (last <= 64'hFFFF_FFFF) && (last <= top);
    end
    if (!ok) begin eF = 1; eVec = isStack ? 12 : 13; end
    else begin eV = 1; eA = (longint'(segBase) + off) & 64'hFFFF_FFFF; end
  endfunction

  task automatic go(input string tag);
    bit eV, eF; int eVec; longint unsigned eA; bit bad;
    predict(eV, eF, eVec, eA);
    @(negedge clk);
    checks++;
    bad = (linValid != eV) || (faultValid != eF) ||
          (eF && faultVector != eVec[7:0]) || (eV && linAddr != eA[31:0]);
    if (bad) begin
      errors++;
      $display("FAIL %s: valid=%0b fault=%0b vec=%0d addr=%h expected valid=%0b fault=%0b vec=%0d addr=%h",
               tag, linValid, faultValid, faultVector, linAddr, eV, eF, eVec, eA[31:0]);
    end
  endtask

  task automatic setSeg(input logic [31:0] b, input logic [19:0] l, input bit g, input bit ed,
                        input bit bg, input bit cd, input bit wr);
    segBase = b; segLimit = l; segGran = g; segExpDown = ed; segBig = bg;
    segCode = cd; segWritable = wr;
  endtask

  task automatic acc(input bit w, input bit s, input logic [31:0] off, input logic [1:0] sz,
                     input string tag);
    reqValid = 1; isWrite = w; isStack = s; offset = off; sizeCode = sz;
    go(tag);
  endtask

  task automatic idle(input string tag);
    reqValid = 0;
    go(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) begin
      reqValid = 1;
      @(negedge clk);
      checks++;
      if (linValid || faultValid) begin
        errors++;
        $display("FAIL R1: valid=%0b fault=%0b expected 0 0", linValid, faultValid);
      end
    end
    reqValid = 0;
    rstN = 1;
    idle("R1 first cycle after reset");

    // R3 byte-granular bound, R5 last byte
    setSeg(32'h1000_0000, 20'h00FFF, 0, 0, 0, 0, 1);
    acc(0, 0, 32'h0000_0FFC, 2'd2, "R3 last byte at limit");
    acc(0, 0, 32'h0000_0FFD, 2'd2, "R5 last byte past limit");
    acc(0, 1, 32'h0000_0FFD, 2'd2, "R7 stack bound fault");
    acc(1, 0, 32'h0000_0000, 2'd3, "R2 write to writable data");
    idle("R9 idle after request");

    // R4 page-granular bound
    setSeg(32'h0002_0000, 20'h00001, 1, 0, 0, 0, 1);
    acc(0, 0, 32'h0000_1FFF, 2'd0, "R4 top byte of scaled bound");
    acc(0, 0, 32'h0000_2000, 2'd0, "R4 one past scaled bound");

    // R10 full segment, R5 wrap, R2 address wrap
    setSeg(32'hFFFF_F000, 20'hFFFFF, 1, 0, 0, 0, 1);
    acc(0, 0, 32'hFFFF_FFF8, 2'd3, "R10 last eight bytes");
    acc(0, 0, 32'hFFFF_FFF9, 2'd3, "R5 offset space wrap");
    acc(0, 0, 32'h0000_2000, 2'd1, "R2 linear sum wraps mod 2^32");

    // R6 grow-downward segments
    setSeg(32'h0030_0000, 20'h00FFF, 0, 1, 0, 0, 1);
    acc(0, 0, 32'h0000_1000, 2'd1, "R6 just above limit");
    acc(0, 1, 32'h0000_0FFF, 2'd0, "R6 at limit stack fault");
    acc(0, 0, 32'h0000_FFFF, 2'd0, "R6 small top byte");
    acc(0, 0, 32'h0000_FFFF, 2'd1, "R6 crosses small top");
    segBig = 1;
    acc(0, 0, 32'h0001_0000, 2'd2, "R6 big segment above 64K");
    setSeg(32'h0, 20'h00000, 0, 1, 1, 0, 1);
    acc(0, 0, 32'h0000_0000, 2'd0, "R6 limit zero offset zero");
    acc(0, 0, 32'h0000_0001, 2'd0, "R6 limit zero offset one");

    // R8 type checks and priority
    setSeg(32'h0040_0000, 20'h000FF, 0, 0, 0, 1, 1);
    acc(1, 1, 32'h0000_0010, 2'd0, "R8 write to code");
    acc(0, 0, 32'h0000_0010, 2'd0, "R2 read of code");
    setSeg(32'h0040_0000, 20'h000FF, 0, 0, 0, 0, 0);
    acc(1, 1, 32'h0000_0200, 2'd0, "R8 read-only stack write out of bounds");
    acc(0, 1, 32'h0000_0200, 2'd0, "R7 read-only stack read out of bounds");

    // R11 grow-downward bit ignored on code
    setSeg(32'h0050_0000, 20'h00FFF, 0, 1, 0, 1, 1);
    acc(0, 0, 32'h0000_0100, 2'd2, "R11 code below limit");
    acc(0, 0, 32'h0000_1000, 2'd0, "R11 code above limit");

    // random phase
    for (int i = 0; i < 400; i++) begin
      int pick;
      logic [31:0] lim32;
      pick = int'($urandom_range(0, 3));
      segLimit = (pick == 0) ? 20'h0 : (pick == 1) ? 20'hFFFFF :
                 (pick == 2) ? 20'($urandom_range(0, 64)) : 20'($urandom);
      segBase = $urandom; segGran = 1'($urandom); segExpDown = 1'($urandom);
      segBig = 1'($urandom); segCode = ($urandom_range(0, 3) == 0);
      segWritable = ($urandom_range(0, 3) != 0);
      lim32 = segGran ? {segLimit, 12'hFFF} : {12'h0, segLimit};
      case ($urandom_range(0, 3))
        0: offset = lim32 + 32'($urandom_range(0, 8)) - 32'd4;
        1: offset = 32'hFFFF_FFF8 + 32'($urandom_range(0, 7));
        2: offset = 32'h0000_FFF8 + 32'($urandom_range(0, 15));
        default: offset = $urandom;
      endcase
      sizeCode = 2'($urandom); isWrite = 1'($urandom); isStack = 1'($urandom);
      reqValid = ($urandom_range(0, 4) != 0);
      go("R2-random R3 R4 R5 R6 R7 R8 R9");
    end
    idle("R9 final idle");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule